// File: doc/BRIEF.md
# Serial Line Transmitter with Readback Collision Abort

This block serialises one asynchronous character at a time onto a single wire. An external quantum tick sets its timing. Every bit on the line spans a fixed count of quanta, set by the `QUANTA` parameter. A character is made of these parts, in order:

- a low start bit;
- a data word of 1 to `DATA_MAX` bits, sent least significant bit first;
- an optional even-parity bit;
- one or two high stop bits.

For infrared-style signalling, a zero bit can be cut down to a short low pulse that lasts a programmable number of quanta. The block leaves the line high for the rest of that bit.

The block also watches the bus through a readback input. When collision checking is on, it compares the readback with the level it is driving once per bit, at a fixed sample quantum. On a mismatch it abandons the character, drives the line high, raises a one-cycle collision interrupt and sets a sticky collision flag. Until a clear strobe removes that flag, the block refuses every new load. A one-cycle finished pulse marks each character that completes normally. Baud-rate generation lives outside the block.

Top module: `uart_cd_tx`

## Requirements
- R1: While `rst` is high, and after it, before any load, `txd` is 1 and `busy`, `col_flag`, `col_irq` and `done` are 0.
- R2: A `load` accepted while idle starts a character. On the clock edge after the accepting edge, `txd` begins with a start bit of level 0. Next come `cfg_len`+1 data bits of `data_in`, sent from bit 0 upward. Each bit lasts `QUANTA` ticks.
- R3: With `cfg_parity` = 1, one extra bit follows the last data bit. Its value makes the count of ones among the sent data bits plus this bit even.
- R4: The character ends with one high stop bit when `cfg_two_stop` = 0, and with two when it is 1.
- R5: A `cfg_pulse` code of 0 keeps each zero bit low for the whole bit. A code N > 0 holds a zero bit low for its first N+1 quanta and high for the rest. When N+1 is at least `QUANTA`, the zero bit stays low for the whole bit.
- R6: `done` is high for exactly one cycle, starting at the clock edge where the last stop bit's final quantum ends.
- R7: With `cfg_busy_en` = 1, `busy` is high from the accepting edge until the finishing (or aborting) edge. With `cfg_busy_en` = 0, `busy` stays 0.
- R8: With `cfg_cd_en` = 1, a collision is a sample tick (a tick while the in-bit quantum count equals `SAMPLE_Q`) on which `rxd` differs from `txd`. A collision ends the character on that edge. `txd` becomes 1, `col_flag` becomes 1 and `col_irq` pulses for one cycle. No `done` pulse is given for that character.
- R9: While `col_flag` is 1, `load` is ignored: `txd` stays 1 and `busy` stays 0. A `col_clr` pulse clears the flag, and loads are accepted again.
- R10: With `cfg_cd_en` = 0, any mismatch between `rxd` and `txd` is ignored and the character completes unchanged.
- R11: A `load` while a character is in progress is ignored. The character in progress keeps its own data and settings.
- R12: Timing advances only on cycles where `tick` is 1. While `tick` is 0, the level on `txd` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Quantum tick, one cycle per quantum |
| load | input | 1 | Start strobe for a new character |
| data_in | input | DATA_MAX | Data word, sampled at load |
| cfg_len | input | $clog2(DATA_MAX) | Data bit count minus one, sampled at load |
| cfg_parity | input | 1 | Append even parity, sampled at load |
| cfg_two_stop | input | 1 | Two stop bits instead of one, sampled at load |
| cfg_pulse | input | PCODE_W | Zero-pulse length code, sampled at load |
| cfg_cd_en | input | 1 | Enables collision checking |
| cfg_busy_en | input | 1 | Enables the busy indication |
| rxd | input | 1 | Readback of the bus level |
| col_clr | input | 1 | Clears the collision flag |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Character in progress |
| col_flag | output | 1 | Sticky collision flag |
| col_irq | output | 1 | One-cycle collision interrupt |
| done | output | 1 | One-cycle character-finished pulse |

## Verification
A wrong quantum count or bit index shows up on `txd` within one bit time. The level is wrong at a single quantum position, and the bench compares every quantum of every character against a model built from the requirements. A wrong parity or stop-count decision appears in the final bits of the character. It also shifts when `done` pulses, so `done` arrives a whole bit early or late. A broken collision path shows up within one bit time of the injected mismatch, as `col_flag` or `col_irq` staying quiet, or as `txd` continuing to toggle. A flag that fails to stay set shows up when a later load is wrongly accepted and `busy` rises.

// File: rtl/uart_cd_pkg.sv
package uart_cd_pkg;
  // Role of the bit currently on the line.
  typedef enum logic [1:0] {
    BK_START  = 2'd0,
    BK_DATA   = 2'd1,
    BK_PARITY = 2'd2,
    BK_STOP   = 2'd3
  } bit_kind_e;
endpackage

// File: rtl/uart_cd_qtimer.sv
module uart_cd_qtimer #(
  parameter int QUANTA   = 8,
  parameter int SAMPLE_Q = 4,
  localparam int QW = $clog2(QUANTA)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  input  logic          tick,
  output logic [QW-1:0] q,
  output logic          bit_end,
  output logic          at_sample
);
  localparam logic [QW-1:0] Q_LAST = QW'(QUANTA - 1);
  localparam logic [QW-1:0] Q_SMP  = QW'(SAMPLE_Q);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      q <= '0;
    end else if (run && tick) begin
      q <= (q == Q_LAST) ? '0 : q + QW'(1);
    end
  end

  assign bit_end   = run && tick && (q == Q_LAST);
  assign at_sample = run && tick && (q == Q_SMP);
endmodule

// File: rtl/uart_cd_seq.sv
module uart_cd_seq
  import uart_cd_pkg::*;
#(
  parameter int DATA_MAX = 8,
  localparam int LEN_W = $clog2(DATA_MAX),
  localparam int IW    = $clog2(DATA_MAX + 5)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                adv,
  input  logic [DATA_MAX-1:0] data_in,
  input  logic [LEN_W-1:0]    len_in,
  input  logic                par_in,
  input  logic                two_in,
  output logic                level,
  output logic                is_last
);
  logic [DATA_MAX-1:0] masked;
  logic [DATA_MAX-1:0] data_r;
  logic [LEN_W-1:0]    len_r;
  logic                par_r, par_bit_r, two_r;
  logic [IW-1:0]       idx, last_data, last_idx, dsel;
  logic                data_bit;
  bit_kind_e           kind;

  // Only the bits that will actually be sent take part in parity.
  for (genvar gi = 0; gi < DATA_MAX; gi++) begin : g_mask
    assign masked[gi] = data_in[gi] & (LEN_W'(gi) <= len_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_r    <= '0;
      len_r     <= '0;
      par_r     <= 1'b0;
      par_bit_r <= 1'b0;
      two_r     <= 1'b0;
      idx       <= '0;
    end else if (start) begin
      data_r    <= masked;
      len_r     <= len_in;
      par_r     <= par_in;
      par_bit_r <= ^masked;
      two_r     <= two_in;
      idx       <= '0;
    end else if (adv) begin
      idx <= idx + IW'(1);
    end
  end

  assign last_data = IW'(len_r) + IW'(1);
  assign last_idx  = IW'(len_r) + IW'(2) + IW'(par_r) + IW'(two_r);
  assign dsel      = idx - IW'(1);

  always_comb begin
    if (idx == '0)                               kind = BK_START;
    else if (idx <= last_data)                   kind = BK_DATA;
    else if (par_r && idx == last_data + IW'(1)) kind = BK_PARITY;
    else                                         kind = BK_STOP;
  end

  always_comb begin
    data_bit = 1'b0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (dsel == IW'(i)) data_bit = data_r[i];
    end
  end

  always_comb begin
    unique case (kind)
      BK_START:  level = 1'b0;
      BK_DATA:   level = data_bit;
      BK_PARITY: level = par_bit_r;
      default:   level = 1'b1;
    endcase
  end

  assign is_last = (idx == last_idx);
endmodule

// File: rtl/uart_cd_shaper.sv
module uart_cd_shaper #(
  parameter int QUANTA  = 8,
  parameter int PCODE_W = 3,
  localparam int QW = $clog2(QUANTA)
) (
  input  logic               level,
  input  logic [QW-1:0]      q,
  input  logic [PCODE_W-1:0] code,
  output logic               line
);
  logic cut;
  // A zero bit returns high once the quantum count passes the code.
  assign cut  = (code != '0) && (int'(q) > int'(code));
  assign line = level | cut;
endmodule

// File: rtl/uart_cd_tx.sv
module uart_cd_tx #(
  parameter int DATA_MAX = 8,
  parameter int QUANTA   = 8,
  parameter int SAMPLE_Q = 4,
  parameter int PCODE_W  = 3,
  localparam int LEN_W = $clog2(DATA_MAX),
  localparam int QW    = $clog2(QUANTA)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                load,
  input  logic [DATA_MAX-1:0] data_in,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                cfg_parity,
  input  logic                cfg_two_stop,
  input  logic [PCODE_W-1:0]  cfg_pulse,
  input  logic                cfg_cd_en,
  input  logic                cfg_busy_en,
  input  logic                rxd,
  input  logic                col_clr,
  output logic                txd,
  output logic                busy,
  output logic                col_flag,
  output logic                col_irq,
  output logic                done
);
  logic               active, active_n, accept, abort, finish;
  logic [QW-1:0]      q_cnt;
  logic               bit_end, at_sample, level, is_last, shaped;
  logic [PCODE_W-1:0] code_r;

  assign accept = load && !active && !col_flag;

  uart_cd_qtimer #(.QUANTA(QUANTA), .SAMPLE_Q(SAMPLE_Q)) qtimer_i (
    .clk(clk), .rst(rst), .clear(accept), .run(active), .tick(tick),
    .q(q_cnt), .bit_end(bit_end), .at_sample(at_sample)
  );

  uart_cd_seq #(.DATA_MAX(DATA_MAX)) seq_i (
    .clk(clk), .rst(rst), .start(accept), .adv(bit_end),
    .data_in(data_in), .len_in(cfg_len), .par_in(cfg_parity),
    .two_in(cfg_two_stop), .level(level), .is_last(is_last)
  );

  uart_cd_shaper #(.QUANTA(QUANTA), .PCODE_W(PCODE_W)) shaper_i (
    .level(level), .q(q_cnt), .code(code_r), .line(shaped)
  );

  assign abort  = active && at_sample && cfg_cd_en && (rxd != txd);
  assign finish = bit_end && is_last && !abort;

  always_comb begin
    active_n = active;
    if (accept)               active_n = 1'b1;
    else if (abort || finish) active_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      txd      <= 1'b1;
      busy     <= 1'b0;
      col_flag <= 1'b0;
      col_irq  <= 1'b0;
      done     <= 1'b0;
      code_r   <= '0;
    end else begin
      active  <= active_n;
      txd     <= (active && !abort) ? shaped : 1'b1;
      busy    <= active_n && cfg_busy_en;
      col_irq <= abort;
      done    <= finish;
      if (accept) code_r <= cfg_pulse;
      if (abort)        col_flag <= 1'b1;
      else if (col_clr) col_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_cd_tx_chk.sv
module uart_cd_tx_chk #(
  parameter int QW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          load,
  input logic          col_clr,
  input logic          cfg_busy_en,
  input logic          txd,
  input logic          busy,
  input logic          col_flag,
  input logic          col_irq,
  input logic          done,
  input logic [QW-1:0] q_cnt
);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_stop_high_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> txd);

  assert_abort_line_R8: assert property (@(posedge clk) disable iff (rst)
    col_irq |-> (txd && col_flag && !done && !busy));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (col_flag && !col_clr) |=> col_flag);

  assert_no_start_R9: assert property (@(posedge clk) disable iff (rst)
    col_flag |-> !busy);

  assert_busy_off_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_busy_en |=> !busy);

  assert_tick_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(q_cnt));
endmodule

bind uart_cd_tx uart_cd_tx_chk #(.QW(QW)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .load(load), .col_clr(col_clr),
  .cfg_busy_en(cfg_busy_en), .txd(txd), .busy(busy), .col_flag(col_flag),
  .col_irq(col_irq), .done(done), .q_cnt(q_cnt)
);

// File: tb/uart_cd_tx_tb.sv
module uart_cd_tx_tb_top;
  localparam int QPB = 8;
  localparam int NV  = 7;
  // {data[7:0], len[2:0], parity, two_stop, pulse[2:0]}
  localparam logic [15:0] VEC [NV] = '{
    {8'hA5, 3'd7, 1'b0, 1'b0, 3'd0},
    {8'h3C, 3'd7, 1'b1, 1'b0, 3'd0},
    {8'h5A, 3'd4, 1'b1, 1'b1, 3'd0},
    {8'hF0, 3'd7, 1'b0, 1'b1, 3'd1},
    {8'h81, 3'd0, 1'b1, 1'b0, 3'd2},
    {8'h00, 3'd7, 1'b1, 1'b1, 3'd7},
    {8'h6B, 3'd6, 1'b0, 1'b0, 3'd3}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, tick, load, cfg_parity, cfg_two_stop, cfg_cd_en, cfg_busy_en;
  logic col_clr, inj, rxd, txd, busy, col_flag, col_irq, done;
  logic [7:0] data_in;
  logic [2:0] cfg_len, cfg_pulse;

  assign rxd = txd ^ inj;

  uart_cd_tx dut_i (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .data_in(data_in),
    .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
    .cfg_pulse(cfg_pulse), .cfg_cd_en(cfg_cd_en), .cfg_busy_en(cfg_busy_en),
    .rxd(rxd), .col_clr(col_clr), .txd(txd), .busy(busy),
    .col_flag(col_flag), .col_irq(col_irq), .done(done)
  );

  int n_chk = 0, n_err = 0, done_cnt = 0, irq_cnt = 0;
  always @(posedge clk) begin
    if (done) done_cnt++;
    if (col_irq) irq_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int frame_q(input logic [15:0] v);
    return (3 + int'(v[7:5]) + int'(v[4]) + int'(v[3])) * QPB;
  endfunction

  function automatic logic exp_level(input logic [15:0] v, input int k);
    int b = k / QPB, q = k % QPB, nb = int'(v[7:5]) + 1;
    logic lvl, p;
    p = 1'b0;
    for (int i = 0; i < nb; i++) p ^= v[8 + i];
    if (b == 0)                  lvl = 1'b0;
    else if (b <= nb)            lvl = v[8 + b - 1];
    else if (b == nb + 1 && v[4]) lvl = p;
    else                         lvl = 1'b1;
    if (!lvl && v[2:0] != 3'd0 && q > int'(v[2:0])) lvl = 1'b1;
    return lvl;
  endfunction

  task automatic set_cfg(input logic [15:0] v);
    data_in = v[15:8]; cfg_len = v[7:5]; cfg_parity = v[4];
    cfg_two_stop = v[3]; cfg_pulse = v[2:0];
  endtask

  // Send one character and compare every quantum on txd (R2..R5), done (R6), busy (R7).
  task automatic run_frame(input logic [15:0] v, input logic cd, input logic ben,
                           input bit mid_load, input string tag);
    int len = frame_q(v);
    int wbad = 0, dbad = 0, bbad = 0, wfirst = -1, wact = 0, wexp = 0;
    @(negedge clk);
    set_cfg(v); cfg_cd_en = cd; cfg_busy_en = ben; load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
    for (int j = 1; j <= len; j++) begin
      @(posedge clk); #1;
      if (txd !== exp_level(v, j - 1)) begin
        wbad++;
        if (wfirst < 0) begin
          wfirst = j - 1; wact = int'(txd); wexp = int'(exp_level(v, j - 1));
        end
      end
      if (done !== (j == len)) dbad++;
      if (busy !== (ben && j < len)) bbad++;
      if (mid_load && j == 30) begin
        data_in = ~v[15:8]; cfg_len = 3'd1; cfg_pulse = 3'd1; load = 1'b1;
      end
      if (mid_load && j == 31) load = 1'b0;
    end
    chk(wbad == 0, {tag, " R2 R3 R4 R5 waveform (first bad quantum level)"}, wact, wexp);
    chk(dbad == 0, {tag, " R6 done pulse position errors"}, dbad, 0);
    chk(bbad == 0, {tag, " R7 busy errors"}, bbad, 0);
    @(posedge clk); #1;
    chk(txd === 1'b1 && done === 1'b0, {tag, " R6 idle after frame"}, int'(txd), 1);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int irq0, d0, hold_bad;
    bit seen;
    rst = 1'b1; tick = 1'b1; load = 1'b0; inj = 1'b0; col_clr = 1'b0;
    cfg_cd_en = 1'b1; cfg_busy_en = 1'b1; set_cfg(VEC[0]);
    repeat (3) @(posedge clk);
    #1;
    chk(txd === 1'b1 && busy === 1'b0 && col_flag === 1'b0 && col_irq === 1'b0 && done === 1'b0,
        "R1 reset outputs", int'({txd, busy, col_flag, col_irq, done}), 16);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    chk(txd === 1'b1 && busy === 1'b0, "R1 idle after reset", int'({txd, busy}), 2);

    // Vector table: loopback readback, collision checking on.
    for (int i = 0; i < NV; i++) begin
      run_frame(VEC[i], 1'b1, (i != 3), 1'b0, $sformatf("vec%0d", i));
    end

    // R11: load in mid-character is ignored.
    run_frame(VEC[0], 1'b1, 1'b1, 1'b1, "R11 midload");

    // R10: readback inverted, collision checking off.
    inj = 1'b1;
    run_frame(VEC[1], 1'b0, 1'b1, 1'b0, "R10 cd_off");
    inj = 1'b0;

    // R8: collision aborts the character.
    irq0 = irq_cnt; d0 = done_cnt;
    @(negedge clk);
    set_cfg(VEC[0]); cfg_cd_en = 1'b1; cfg_busy_en = 1'b1; load = 1'b1;
    @(negedge clk) load = 1'b0;
    repeat (18) @(negedge clk);
    inj = 1'b1;
    repeat (12) @(negedge clk);
    chk(col_flag === 1'b1, "R8 collision flag set", int'(col_flag), 1);
    chk(txd === 1'b1 && busy === 1'b0, "R8 line high after abort", int'({txd, busy}), 2);
    chk(irq_cnt == irq0 + 1, "R8 one interrupt pulse", irq_cnt - irq0, 1);
    inj = 1'b0;
    repeat (QPB * 12) @(negedge clk);
    chk(done_cnt == d0, "R8 no done for aborted frame", done_cnt - d0, 0);

    // R9: loads blocked while the flag is set; clear re-enables.
    load = 1'b1;
    @(negedge clk) load = 1'b0;
    hold_bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (txd !== 1'b1 || busy !== 1'b0) hold_bad++;
    end
    chk(hold_bad == 0, "R9 load ignored while flagged", hold_bad, 0);
    chk(col_flag === 1'b1, "R9 flag stays set", int'(col_flag), 1);
    col_clr = 1'b1;
    @(negedge clk) col_clr = 1'b0;
    chk(col_flag === 1'b0, "R9 flag cleared", int'(col_flag), 0);
    run_frame(VEC[2], 1'b1, 1'b1, 1'b0, "R9 after clear");

    // R12: no tick, no progress.
    @(negedge clk);
    set_cfg(VEC[0]); cfg_cd_en = 1'b0; load = 1'b1;
    @(posedge clk);
    @(negedge clk) load = 1'b0;
    repeat (3) @(posedge clk);
    #1 tick = 1'b0;
    hold_bad = 0;
    repeat (20) begin
      @(posedge clk); #1;
      if (txd !== 1'b0) hold_bad++;
    end
    chk(hold_bad == 0, "R12 line held without tick", hold_bad, 0);
    tick = 1'b1;
    repeat (5) @(posedge clk);
    #1 chk(txd === 1'b0, "R12 still in start bit after resume", int'(txd), 0);
    @(posedge clk); #1;
    chk(txd === 1'b1, "R12 first data bit after resume", int'(txd), 1);
    seen = 1'b0;
    for (int k = 0; k < 200 && !seen; k++) begin
      @(posedge clk); #1;
      if (done) seen = 1'b1;
    end
    chk(seen, "R12 frame completes after resume", int'(seen), 1);

    summary();
    $finish;
  end
endmodule